// File: doc/BRIEF.md
# Multicycle Fetch-Decode Control Sequencer

This block is the control sequencer of a small 32-bit multicycle load/store core. Each instruction is fetched in fixed steps. The program counter is staged into an address register, and the single-port memory is read into a data register. The program counter is then advanced by one word, and the instruction register is loaded from the data register. A decode step then dispatches to a short execute sequence for register-to-register ALU operations, word loads, word stores or conditional branches. Every sequence ends back at fetch.

The fetch staging registers (program counter, address, data and instruction registers) sit inside the block. The surrounding datapath supplies the ALU result and the zero flag. In return it receives the register write strobe, the write-back data, the ALU operation code, the immediate operand select and the sign-extended immediate. After reset the sequencer waits in an idle state until the enable input is raised. Dropping enable during fetch freezes it in place.

Top module: `mcs_seq`

## Requirements
- R1: While reset is active, and afterwards until `en_i` is first high, the program counter, instruction register and memory address all read 0 and no memory or register strobe is asserted.
- R2: Fetch reads memory once at the program counter, advances the program counter by 4 and loads the instruction register with the read word. An opcode other than 0x00, 0x23, 0x2B or 0x04 (bits 31:26) issues no further strobe, and the next fetch read follows the previous one by exactly 5 cycles.
- R3: Opcode 0x00 pulses `reg_we_o` for one cycle with `wb_data_o` equal to `alu_res_i`, and the next fetch read comes 7 cycles after the previous one. `alu_op_o` follows the funct field (bits 5:0): 0x20 gives 0 (add), 0x22 gives 1 (sub), 0x24 gives 2 (and), 0x25 gives 3 (or), 0x2A gives 4 (slt), and any other value gives 0.
- R4: Opcode 0x23 (load) raises `alu_src_b_o` for one cycle with `alu_op_o` = 0. It takes `alu_res_i` as the address, issues one read there, then pulses `reg_we_o` once with `wb_data_o` equal to the word read. The instruction period is 8 cycles.
- R5: Opcode 0x2B (store) raises `alu_src_b_o` for one cycle with `alu_op_o` = 0. It then pulses `mem_wr_o` once with `mem_addr_o` equal to `alu_res_i`, and does not write the register file. The instruction period is 7 cycles.
- R6: Opcode 0x04 (branch if equal) issues no strobe and has a 6-cycle period. If `zero_i` is high the next program counter is PC+4 plus the sign-extended offset (bits 15:0) shifted left by two. Otherwise it is PC+4.
- R7: While `en_i` is low in any fetch step the state is held, no memory strobe is issued and the program counter does not move. Fetch resumes where it stopped.
- R8: `imm_o` is bits 15:0 of the instruction register, sign-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Start / run enable |
| mem_rdata_i | input | 32 | Memory read data, valid while the read strobe is high |
| alu_res_i | input | 32 | ALU result from the datapath |
| zero_i | input | 1 | ALU zero flag |
| mem_addr_o | output | 32 | Memory address (staged address register) |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| pc_o | output | 32 | Program counter |
| ir_o | output | 32 | Instruction register |
| imm_o | output | 32 | Sign-extended immediate |
| alu_op_o | output | 3 | ALU operation: 0 add, 1 sub, 2 and, 3 or, 4 slt |
| alu_src_b_o | output | 1 | ALU operand B select: 1 = immediate |
| reg_we_o | output | 1 | Register file write enable |
| wb_data_o | output | 32 | Write-back data: loaded word or ALU result |

## Verification
The bench sweeps all 64 opcode values. The cycle count between consecutive fetch reads separates the 5-, 6-, 7- and 8-cycle paths, and the strobe counts show that only the load and store paths touch data memory. All 64 funct values are run under opcode 0 to show that exactly five codes select distinct ALU operations and every other value falls back to add. Branches are tried taken with forward, zero and backward offsets and also not taken, which tells the offset adder apart from the plain increment. Fetch holds of several lengths show that the period stretches by exactly the hold and that no strobe leaks out.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [3:0] {
    S_INIT, S_FMAR, S_FRD, S_FPC, S_FIR, S_DEC,
    S_REX, S_RWB, S_MADR, S_LRD, S_LWB, S_SWR, S_BR
  } state_e;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0, ALU_SUB = 3'd1, ALU_AND = 3'd2, ALU_OR = 3'd3, ALU_SLT = 3'd4
  } alu_op_e;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;
endpackage

// File: rtl/mcs_alu_dec.sv
module mcs_alu_dec
  import mcs_pkg::*;
(
  input  logic [5:0] funct_i,
  output alu_op_e    op_o
);
  always_comb begin
    unique case (funct_i)
      FN_SUB:  op_o = ALU_SUB;
      FN_AND:  op_o = ALU_AND;
      FN_OR:   op_o = ALU_OR;
      FN_SLT:  op_o = ALU_SLT;
      default: op_o = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/mcs_fetch.sv
module mcs_fetch #(
  parameter int unsigned      XLEN   = 32,
  parameter logic [XLEN-1:0]  RST_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            mar_pc_i,
  input  logic            mar_alu_i,
  input  logic            mdr_ld_i,
  input  logic            pc_inc_i,
  input  logic            pc_br_i,
  input  logic            ir_ld_i,
  input  logic [XLEN-1:0] rdata_i,
  input  logic [XLEN-1:0] alu_res_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] mar_o,
  output logic [XLEN-1:0] mdr_o,
  output logic [XLEN-1:0] ir_o,
  output logic [XLEN-1:0] imm_o
);
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned PC_STEP = XLEN / 8;

  logic [XLEN-1:0] pc_q, mar_q, mdr_q, ir_q, imm_sx;

  assign imm_sx = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= RST_PC;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
    end else if (clr_i) begin
      pc_q  <= RST_PC;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
    end else begin
      if (pc_inc_i)     pc_q <= pc_q + XLEN'(PC_STEP);
      else if (pc_br_i) pc_q <= pc_q + (imm_sx << 2);
      if (mar_pc_i)       mar_q <= pc_q;
      else if (mar_alu_i) mar_q <= alu_res_i;
      if (mdr_ld_i) mdr_q <= rdata_i;
      if (ir_ld_i)  ir_q  <= mdr_q;
    end
  end

  assign pc_o  = pc_q;
  assign mar_o = mar_q;
  assign mdr_o = mdr_q;
  assign ir_o  = ir_q;
  assign imm_o = imm_sx;

  // R7
  pc_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pc_inc_i && !pc_br_i && !clr_i) |=> $stable(pc_q));
endmodule

// File: rtl/mcs_fsm.sv
module mcs_fsm
  import mcs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [5:0] opcode_i,
  input  alu_op_e    funct_op_i,
  input  logic       zero_i,
  output logic       clr_o,
  output logic       mar_pc_o,
  output logic       mar_alu_o,
  output logic       mdr_ld_o,
  output logic       pc_inc_o,
  output logic       pc_br_o,
  output logic       ir_ld_o,
  output logic       mem_rd_o,
  output logic       mem_wr_o,
  output logic       reg_we_o,
  output logic       wb_mem_o,
  output logic       alu_src_b_o,
  output alu_op_e    alu_op_o
);
  state_e state_q, state_d;
  logic   in_fetch;

  assign in_fetch = (state_q == S_FMAR) || (state_q == S_FRD) ||
                    (state_q == S_FPC)  || (state_q == S_FIR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_INIT;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d     = state_q;
    clr_o       = 1'b0;
    mar_pc_o    = 1'b0;
    mar_alu_o   = 1'b0;
    mdr_ld_o    = 1'b0;
    pc_inc_o    = 1'b0;
    pc_br_o     = 1'b0;
    ir_ld_o     = 1'b0;
    mem_rd_o    = 1'b0;
    mem_wr_o    = 1'b0;
    reg_we_o    = 1'b0;
    wb_mem_o    = 1'b0;
    alu_src_b_o = 1'b0;
    alu_op_o    = ALU_ADD;
    unique case (state_q)
      S_INIT: begin
        clr_o = 1'b1;
        if (en_i) state_d = S_FMAR;
      end
      S_FMAR: if (en_i) begin mar_pc_o = 1'b1; state_d = S_FRD; end
      S_FRD:  if (en_i) begin mem_rd_o = 1'b1; mdr_ld_o = 1'b1; state_d = S_FPC; end
      S_FPC:  if (en_i) begin pc_inc_o = 1'b1; state_d = S_FIR; end
      S_FIR:  if (en_i) begin ir_ld_o = 1'b1; state_d = S_DEC; end
      S_DEC: begin
        unique case (opcode_i)
          OP_RTYPE:     state_d = S_REX;
          OP_LW, OP_SW: state_d = S_MADR;
          OP_BEQ:       state_d = S_BR;
          default:      state_d = S_FMAR;
        endcase
      end
      S_REX: begin alu_op_o = funct_op_i; state_d = S_RWB; end
      S_RWB: begin alu_op_o = funct_op_i; reg_we_o = 1'b1; state_d = S_FMAR; end
      S_MADR: begin
        alu_src_b_o = 1'b1;
        mar_alu_o   = 1'b1;
        state_d     = (opcode_i == OP_LW) ? S_LRD : S_SWR;
      end
      S_LRD: begin mem_rd_o = 1'b1; mdr_ld_o = 1'b1; state_d = S_LWB; end
      S_LWB: begin reg_we_o = 1'b1; wb_mem_o = 1'b1; state_d = S_FMAR; end
      S_SWR: begin mem_wr_o = 1'b1; state_d = S_FMAR; end
      S_BR: begin
        alu_op_o = ALU_SUB;
        pc_br_o  = zero_i;
        state_d  = S_FMAR;
      end
      default: state_d = S_INIT;
    endcase
  end

  // R7
  fetch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fetch && !en_i) |=> (state_q == $past(state_q)));
  // R3
  we_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  // R5
  wr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> !mem_wr_o);
  // R2
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o) && !(reg_we_o && mem_wr_o));
  // R2
  read_then_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fetch && mem_rd_o) |=> (state_q == S_FPC));
endmodule

// File: rtl/mcs_seq.sv
module mcs_seq
  import mcs_pkg::*;
#(
  parameter int unsigned     XLEN   = 32,
  parameter logic [XLEN-1:0] RST_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  input  logic [XLEN-1:0] alu_res_i,
  input  logic            zero_i,
  output logic [XLEN-1:0] mem_addr_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] ir_o,
  output logic [XLEN-1:0] imm_o,
  output logic [2:0]      alu_op_o,
  output logic            alu_src_b_o,
  output logic            reg_we_o,
  output logic [XLEN-1:0] wb_data_o
);
  localparam int unsigned OPC_LSB = XLEN - 6;

  logic    clr, mar_pc, mar_alu, mdr_ld, pc_inc, pc_br, ir_ld, wb_mem;
  logic [XLEN-1:0] mdr;
  alu_op_e funct_op, alu_op;

  mcs_fetch #(.XLEN(XLEN), .RST_PC(RST_PC)) u_fetch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .mar_pc_i  (mar_pc),
    .mar_alu_i (mar_alu),
    .mdr_ld_i  (mdr_ld),
    .pc_inc_i  (pc_inc),
    .pc_br_i   (pc_br),
    .ir_ld_i   (ir_ld),
    .rdata_i   (mem_rdata_i),
    .alu_res_i (alu_res_i),
    .pc_o      (pc_o),
    .mar_o     (mem_addr_o),
    .mdr_o     (mdr),
    .ir_o      (ir_o),
    .imm_o     (imm_o)
  );

  mcs_alu_dec u_alu_dec (
    .funct_i (ir_o[5:0]),
    .op_o    (funct_op)
  );

  mcs_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .opcode_i    (ir_o[OPC_LSB +: 6]),
    .funct_op_i  (funct_op),
    .zero_i      (zero_i),
    .clr_o       (clr),
    .mar_pc_o    (mar_pc),
    .mar_alu_o   (mar_alu),
    .mdr_ld_o    (mdr_ld),
    .pc_inc_o    (pc_inc),
    .pc_br_o     (pc_br),
    .ir_ld_o     (ir_ld),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .reg_we_o    (reg_we_o),
    .wb_mem_o    (wb_mem),
    .alu_src_b_o (alu_src_b_o),
    .alu_op_o    (alu_op)
  );

  assign alu_op_o  = alu_op;
  assign wb_data_o = wb_mem ? mdr : alu_res_i;

  // R4
  load_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && !mar_pc && pc_o != mem_addr_o) |=> (wb_data_o == $past(mem_rdata_i)));
endmodule

// File: tb/mcs_seq_tb.sv
module mcs_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [31:0] mem_rdata_i, alu_res_i;
  logic        zero_i;
  logic [31:0] mem_addr_o, pc_o, ir_o, imm_o, wb_data_o;
  logic        mem_rd_o, mem_wr_o, alu_src_b_o, reg_we_o;
  logic [2:0]  alu_op_o;

  logic [31:0] imem [64];
  logic [31:0] exp_pc;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  assign mem_rdata_i = (mem_addr_o[31:12] != 20'd0) ? (mem_addr_o ^ 32'hA5A5_0000)
                                                    : imem[mem_addr_o[7:2]];

  mcs_seq u_dut (
    .clk_i, .rst_ni, .en_i, .mem_rdata_i, .alu_res_i, .zero_i,
    .mem_addr_o, .mem_rd_o, .mem_wr_o, .pc_o, .ir_o, .imm_o,
    .alu_op_o, .alu_src_b_o, .reg_we_o, .wb_data_o
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] funct_op(input logic [5:0] f);
    case (f)
      6'h20: return 3'd0;
      6'h22: return 3'd1;
      6'h24: return 3'd2;
      6'h25: return 3'd3;
      6'h2A: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  task automatic exec(input logic [31:0] instr, input logic zero,
                      input logic [31:0] alu, input int hold);
    automatic logic [5:0]  op = instr[31:26];
    automatic logic [31:0] sx = {{16{instr[15]}}, instr[15:0]};
    automatic int e_per = 5, e_we = 0, e_wr = 0, e_rd = 0, e_src = 0;
    automatic logic [31:0] e_next = exp_pc + 32'd4;
    automatic logic [31:0] e_wb = 32'd0;
    automatic string req = "R2";
    automatic int per = 0, we = 0, wr = 0, drd = 0, src = 0, guard = 0;
    automatic logic [31:0] got_wb = 32'd0, got_waddr = 32'd0, got_raddr = 32'd0;
    automatic logic [2:0]  got_op = 3'd7, got_src_op = 3'd7;
    case (op)
      6'h00: begin req = "R3"; e_per = 7; e_we = 1; e_wb = alu; end
      6'h23: begin req = "R4"; e_per = 8; e_we = 1; e_rd = 1; e_src = 1;
                   e_wb = alu ^ 32'hA5A5_0000; end
      6'h2B: begin req = "R5"; e_per = 7; e_wr = 1; e_src = 1; end
      6'h04: begin req = "R6"; e_per = 6; if (zero) e_next = exp_pc + 32'd4 + (sx << 2); end
      default: ;
    endcase
    imem[exp_pc[7:2]] = instr;
    zero_i = zero;
    alu_res_i = alu;
    while (!(mem_rd_o && mem_addr_o == exp_pc)) begin
      @(negedge clk_i);
      guard++;
      if (guard > 40) begin chk("R2", "fetch read missing", mem_addr_o, exp_pc); return; end
    end
    if (hold > 0) begin
      en_i = 1'b0;
      for (int h = 0; h < hold; h++) begin
        @(negedge clk_i);
        per++;
        chk("R7", "strobe while held", {30'd0, mem_rd_o, mem_wr_o}, 32'd0);
        chk("R7", "pc while held", pc_o, exp_pc + 32'd0);
      end
      en_i = 1'b1;
    end
    do begin
      @(negedge clk_i);
      per++;
      if (reg_we_o) begin we++; got_wb = wb_data_o; got_op = alu_op_o; end
      if (mem_wr_o) begin wr++; got_waddr = mem_addr_o; end
      if (mem_rd_o && mem_addr_o != e_next) begin drd++; got_raddr = mem_addr_o; end
      if (alu_src_b_o) begin src++; got_src_op = alu_op_o; end
    end while (!(mem_rd_o && mem_addr_o == e_next) && per < 60);
    chk(req, "period", per, e_per + hold);
    chk(req, "reg_we pulses", we, e_we);
    chk(req, "mem_wr pulses", wr, e_wr);
    chk(req, "data reads", drd, e_rd);
    chk(req, "imm select cycles", src, e_src);
    chk("R2", "next pc", pc_o, e_next);
    chk("R2", "ir", ir_o, instr);
    chk("R8", "imm", imm_o, sx);
    if (op == 6'h00) begin
      chk("R3", "alu op", {29'd0, got_op}, {29'd0, funct_op(instr[5:0])});
      chk("R3", "wb data", got_wb, e_wb);
    end
    if (op == 6'h23) begin
      chk("R4", "read addr", got_raddr, alu);
      chk("R4", "wb data", got_wb, e_wb);
      chk("R4", "addr alu op", {29'd0, got_src_op}, 32'd0);
    end
    if (op == 6'h2B) begin
      chk("R5", "write addr", got_waddr, alu);
      chk("R5", "addr alu op", {29'd0, got_src_op}, 32'd0);
    end
    exp_pc = e_next;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) imem[i] = 32'd0;
    zero_i = 1'b0;
    alu_res_i = 32'd0;
    exp_pc = 32'd0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1", "pc in reset", pc_o, 32'd0);
    chk("R1", "ir in reset", ir_o, 32'd0);
    chk("R1", "addr in reset", mem_addr_o, 32'd0);
    chk("R1", "strobes in reset", {29'd0, mem_rd_o, mem_wr_o, reg_we_o}, 32'd0);
    rst_ni = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      chk("R1", "idle strobes", {29'd0, mem_rd_o, mem_wr_o, reg_we_o}, 32'd0);
      chk("R1", "idle pc", pc_o, 32'd0);
    end
    en_i = 1'b1;

    // R2..R6: opcode sweep
    for (int op = 0; op < 64; op++) begin
      automatic logic [31:0] ins = {op[5:0], 5'd3, 5'd4, 16'h0820};
      exec(ins, 1'b0, 32'h0000_2000 + 32'(op) * 32'd4, 0);
    end
    // R3: funct sweep
    for (int f = 0; f < 64; f++)
      exec({6'h00, 5'd1, 5'd2, 5'd3, 5'd0, f[5:0]}, 1'b0, 32'h1234_0000 + 32'(f), 0);
    // R4/R5: negative offsets and varied addresses
    exec({6'h23, 5'd1, 5'd2, 16'hFFF0}, 1'b0, 32'hDEAD_1000, 0);
    exec({6'h2B, 5'd1, 5'd2, 16'h8000}, 1'b0, 32'h0000_3FFC, 0);
    exec({6'h23, 5'd7, 5'd8, 16'h0004}, 1'b0, 32'h8000_0000, 0);
    // R6: branch variants
    exec({6'h04, 5'd1, 5'd2, 16'h0003}, 1'b1, 32'd0, 0);
    exec({6'h04, 5'd1, 5'd2, 16'hFFFB}, 1'b1, 32'd0, 0);
    exec({6'h04, 5'd1, 5'd2, 16'h0000}, 1'b1, 32'd0, 0);
    exec({6'h04, 5'd1, 5'd2, 16'h0007}, 1'b0, 32'd5, 0);
    exec({6'h04, 5'd1, 5'd2, 16'hFFF8}, 1'b0, 32'd1, 0);
    // R7: fetch holds
    exec({6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h22}, 1'b0, 32'h0000_0055, 3);
    exec({6'h3F, 26'd0}, 1'b0, 32'd0, 1);
    exec({6'h2B, 5'd1, 5'd2, 16'h0010}, 1'b0, 32'h0000_5000, 4);
    exec({6'h00, 5'd0, 5'd0, 5'd0, 5'd0, 6'h20}, 1'b0, 32'd9, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule